// File: doc/BRIEF.md
# Single-Wire Monitor Serial Port

A half-duplex asynchronous serial port that connects an on-chip debug monitor to a host over one shared pin. Characters are framed as NRZ mark/space: the line rests high, a low start bit opens each character, eight data bits follow least-significant first, and a high stop bit closes it. Receive and transmit share one bit period, set by the parameter `BIT_CLKS` in bus clocks. At the default of 254 this gives about 6300 baud from a 1.6 MHz bus clock.

The pin is modelled as an open-drain-style driver: an output enable plus a drive value, with the line floating high whenever the enable is low. On the internal side, the receiver reports each good byte with a one-cycle valid pulse. It reports a bad stop bit with a framing-error pulse. A break (a start bit and nine further zero bits, so the stop position is also low) raises a one-cycle break pulse. The port answers a break on its own: it drives the line high for two bit times, then sends a break of ten zero bits back. The transmitter accepts a byte only while idle and stays busy until its stop bit has ended. While the port drives the pin, the receiver does not decode the line.

Top module: `sw_mon_port`

## Requirements
- R1: After reset, `line_oe_o`, `tx_busy_o`, `rx_valid_o`, `rx_err_o` and `brk_det_o` are all 0.
- R2: A frame received on `line_i` (start 0, bits 0..7 with the LSB first, stop 1, each bit `BIT_CLKS` cycles long) produces a one-cycle `rx_valid_o` pulse with the byte on `rx_data_o`. `rx_data_o` keeps that byte until the next valid pulse.
- R3: The start bit is confirmed by a second sample half a bit after the falling edge. A low pulse shorter than half a bit produces no valid, error or break pulse.
- R4: A frame whose stop position samples 0 while its data byte is not zero produces a one-cycle `rx_err_o` pulse and no `rx_valid_o`, and it leaves `rx_data_o` unchanged.
- R5: A start bit followed by nine zero bits produces a one-cycle `brk_det_o` pulse and neither `rx_valid_o` nor `rx_err_o`.
- R6: In the cycle after `brk_det_o`, the port drives the line high (`line_oe_o`=1, `line_o`=1) for exactly 2*`BIT_CLKS` cycles. It then drives 0 for 10*`BIT_CLKS` cycles, then releases the line. A break takes priority over a transmit request in the same cycle.
- R7: A `tx_req_i` sampled while the port is idle is accepted. From the next cycle the port drives start 0, `tx_data_i` bits 0..7 and stop 1, each for `BIT_CLKS` cycles. `tx_busy_o` is high for exactly those 10*`BIT_CLKS` cycles.
- R8: A `tx_req_i` that arrives while `tx_busy_o` is high is ignored: the frame being sent is not altered and no further frame follows.
- R9: While the port drives the pin (a byte, the high interval or the break echo), the receiver decodes nothing, so the port's own output never raises a valid, error or break pulse.
- R10: Whenever `tx_busy_o` is low, `line_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled level of the shared pin |
| line_oe_o | output | 1 | Pin drive enable |
| line_o | output | 1 | Pin drive value while enabled |
| rx_valid_o | output | 1 | One-cycle pulse: received byte ready |
| rx_data_o | output | 8 | Last good received byte |
| rx_err_o | output | 1 | One-cycle pulse: stop bit low, data not zero |
| brk_det_o | output | 1 | One-cycle pulse: break received |
| tx_req_i | input | 1 | Transmit request |
| tx_data_i | input | 8 | Byte to transmit |
| tx_busy_o | output | 1 | Port is driving the pin |

## Verification
The bench receives the bytes 0xA5, 0x00, 0xFF, 0x01 and 0x80. These separate bit ordering from inversion, and they separate an all-zero byte with a good stop bit from a break. A sub-half-bit glitch tests start confirmation. A byte with a low stop bit tests the framing error against the break. A reference model built from bit queues predicts the pin enable and value on every cycle for transmitted bytes and for the break answer. This covers the exact length of the two-bit high interval, the ten-bit echo, and a request issued mid-frame that must be ignored. Sending 0x00 and echoing the break show that the port's own output, which would decode as a valid frame or a second break, is not decoded.

// File: rtl/sw_mon_pkg.sv
package sw_mon_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE, TX_HOLD, TX_SEND
  } tx_state_e;
endpackage

// File: rtl/sw_mon_rx.sv
module sw_mon_rx
  import sw_mon_pkg::*;
#(
  parameter int BIT_CLKS = 254,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              line_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              brk_o
);
  localparam int CNT_W = $clog2(BIT_CLKS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BIT_CLKS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic              rx_s;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      brk_o   <= 1'b0;
      if (!en_i) begin
        // own output on the pin: wait for a released high line afterwards
        state_q <= RX_WAIT;
      end else begin
        unique case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rx_s) state_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == HALF_LAST) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == BIT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST) state_q <= RX_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == BIT_LAST) begin
              cnt_q <= '0;
              if (rx_s) begin
                valid_o <= 1'b1;
                data_o  <= sh_q;
                state_q <= RX_IDLE;
              end else begin
                if (sh_q == '0) brk_o <= 1'b1;
                else            err_o <= 1'b1;
                state_q <= RX_WAIT;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_WAIT: begin
            cnt_q <= '0;
            if (rx_s) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sw_mon_tx.sv
module sw_mon_tx
  import sw_mon_pkg::*;
#(
  parameter int BIT_CLKS = 254,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              brk_i,
  output logic              busy_o,
  output logic              oe_o,
  output logic              out_o
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int HOLD_CLKS  = 2 * BIT_CLKS;
  localparam int CNT_W      = $clog2(HOLD_CLKS);
  localparam int BIDX_W     = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0]  BIT_LAST  = CNT_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0]  HOLD_LAST = CNT_W'(HOLD_CLKS - 1);
  localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(FRAME_BITS - 1);

  tx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BIDX_W-1:0]     bidx_q;
  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '1;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          cnt_q  <= '0;
          bidx_q <= '0;
          if (brk_i) begin
            state_q <= TX_HOLD;
            sh_q    <= '0;             // echo: ten zero bits
          end else if (req_i) begin
            state_q <= TX_SEND;
            sh_q    <= {1'b1, data_i, 1'b0};
          end
        end
        TX_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            cnt_q   <= '0;
            state_q <= TX_SEND;
          end else cnt_q <= cnt_q + 1'b1;
        end
        TX_SEND: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q <= '0;
            sh_q  <= {1'b0, sh_q[FRAME_BITS-1:1]};
            if (bidx_q == BIDX_LAST) state_q <= TX_IDLE;
            else                     bidx_q  <= bidx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != TX_IDLE);
  assign oe_o   = (state_q != TX_IDLE);
  assign out_o  = (state_q == TX_SEND) ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sw_mon_port.sv
module sw_mon_port #(
  parameter int BIT_CLKS = 254,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic              line_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_err_o,
  output logic              brk_det_o,
  input  logic              tx_req_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_busy_o
);
  logic tx_busy;
  logic brk;

  sw_mon_rx #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!tx_busy),
    .line_i  (line_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .err_o   (rx_err_o),
    .brk_o   (brk)
  );

  sw_mon_tx #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (tx_req_i),
    .data_i (tx_data_i),
    .brk_i  (brk),
    .busy_o (tx_busy),
    .oe_o   (line_oe_o),
    .out_o  (line_o)
  );

  assign brk_det_o = brk;
  assign tx_busy_o = tx_busy;
endmodule

// File: rtl/sw_mon_port_chk.sv
module sw_mon_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_oe_o,
  input logic              line_o,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_err_o,
  input logic              brk_det_o,
  input logic              tx_req_i,
  input logic              tx_busy_o
);
  a_r10_release_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> !line_oe_o);

  a_r7_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && !tx_busy_o && !brk_det_o) |=> (line_oe_o && !line_o));

  a_r6_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_det_o |=> (tx_busy_o && line_oe_o && line_o));

  a_r4_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_data_o));

  a_r9_quiet_during_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_o && $past(tx_busy_o)) |-> !(rx_valid_o || rx_err_o || brk_det_o));

  a_r5_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_o, rx_err_o, brk_det_o}));

  a_r2_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind sw_mon_port sw_mon_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_oe_o  (line_oe_o),
  .line_o     (line_o),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o),
  .rx_err_o   (rx_err_o),
  .brk_det_o  (brk_det_o),
  .tx_req_i   (tx_req_i),
  .tx_busy_o  (tx_busy_o)
);

// File: tb/sw_mon_port_test.sv
module sw_mon_port_test;
  localparam int B = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic       host_val = 1'b1;
  logic       tx_req = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       line_oe, line_out, rx_valid, rx_err, brk_det, tx_busy;
  logic [7:0] rx_data;
  logic       line;

  assign line = (line_oe ? line_out : 1'b1) & host_val;

  sw_mon_port #(.BIT_CLKS(B), .DATA_W(8)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .line_i     (line),
    .line_oe_o  (line_oe),
    .line_o     (line_out),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data),
    .rx_err_o   (rx_err),
    .brk_det_o  (brk_det),
    .tx_req_i   (tx_req),
    .tx_data_i  (tx_data),
    .tx_busy_o  (tx_busy)
  );

  int checks = 0, fails = 0, mism = 0;
  int n_valid = 0, n_err = 0, n_brk = 0;
  logic [7:0] last_rx = 8'h00;
  bit exp_q[$];
  bit was_idle;
  bit exp_oe;

  // reference model: expected pin drive per cycle
  always @(posedge clk) begin
    if (!rst_ni) begin
      exp_q.delete();
    end else begin
      was_idle = (exp_q.size() == 0);
      if (!was_idle) void'(exp_q.pop_front());
      if (was_idle) begin
        if (brk_det) begin
          for (int i = 0; i < 2 * B; i++) exp_q.push_back(1'b1);
          for (int i = 0; i < 10 * B; i++) exp_q.push_back(1'b0);
        end else if (tx_req) begin
          for (int b = 0; b < 10; b++) begin
            bit v;
            v = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : tx_data[b-1];
            for (int i = 0; i < B; i++) exp_q.push_back(v);
          end
        end
      end
      if (rx_valid) begin n_valid++; last_rx = rx_data; end
      if (rx_err) n_err++;
      if (brk_det) n_brk++;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      exp_oe = (exp_q.size() != 0);
      if (line_oe !== exp_oe || tx_busy !== exp_oe ||
          (exp_oe && line_out !== exp_q[0]))
        mism++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_bits(input logic [9:0] bits);
    for (int i = 0; i < 10; i++) begin
      host_val = bits[i];
      repeat (B) @(negedge clk);
    end
    host_val = 1'b1;
  endtask

  task automatic do_tx(input logic [7:0] d);
    tx_req = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (tx_busy) @(negedge clk);
    repeat (B) @(negedge clk);
  endtask

  initial begin
    logic [7:0] pats [5] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80};
    int v0, e0, k0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(line_oe == 1'b0, "R1 oe after reset", line_oe, 0);
    chk(tx_busy == 1'b0, "R1 busy after reset", tx_busy, 0);
    chk(!rx_valid && !rx_err && !brk_det, "R1 no pulses after reset",
        {rx_valid, rx_err, brk_det}, 0);

    foreach (pats[i]) begin
      v0 = n_valid;
      drive_bits({1'b1, pats[i], 1'b0});
      repeat (B) @(negedge clk);
      chk(n_valid == v0 + 1 && last_rx == pats[i], "R2 byte received", last_rx, pats[i]);
    end
    repeat (3 * B) @(negedge clk);
    chk(rx_data == 8'h80, "R2 data held", rx_data, 8'h80);

    v0 = n_valid; e0 = n_err; k0 = n_brk;
    host_val = 1'b0;
    repeat (B / 4) @(negedge clk);
    host_val = 1'b1;
    repeat (12 * B) @(negedge clk);
    chk(n_valid == v0 && n_err == e0 && n_brk == k0, "R3 glitch rejected",
        n_valid + n_err + n_brk, v0 + e0 + k0);

    drive_bits({1'b0, 8'h3C, 1'b0});
    repeat (B) @(negedge clk);
    chk(n_err == e0 + 1, "R4 framing error", n_err, e0 + 1);
    chk(n_valid == v0, "R4 no valid", n_valid, v0);
    chk(rx_data == 8'h80, "R4 data kept", rx_data, 8'h80);

    do_tx(8'h5A);
    wait_idle();
    chk(mism == 0, "R7 transmit waveform", mism, 0);
    chk(n_valid == v0 && n_brk == k0, "R9 own byte not decoded", n_valid, v0);

    do_tx(8'h00);
    repeat (3 * B) @(negedge clk);
    do_tx(8'hFF);
    wait_idle();
    chk(mism == 0, "R8 request while busy ignored", mism, 0);
    chk(n_valid == v0 && n_err == e0 + 1, "R9 own zero byte not decoded", n_valid, v0);

    drive_bits(10'b0);
    chk(n_brk == k0 + 1, "R5 break detected", n_brk, k0 + 1);
    chk(n_valid == v0 && n_err == e0 + 1, "R5 no valid or error on break",
        n_valid + n_err, v0 + e0 + 1);
    wait_idle();
    chk(mism == 0, "R6 hold and echo waveform", mism, 0);
    repeat (12 * B) @(negedge clk);
    chk(n_brk == k0 + 1, "R9 echoed break not decoded", n_brk, k0 + 1);

    drive_bits({1'b1, 8'hC3, 1'b0});
    repeat (B) @(negedge clk);
    chk(n_valid == v0 + 1 && last_rx == 8'hC3, "R2 receive after break", last_rx, 8'hC3);
    chk(mism == 0, "R10 line released while idle", mism, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule